// File: doc/BRIEF.md
# Supply Start-Up and Reset Sequencer

This block brings up the power rails of a motor-driver die in a fixed order once the main supply is valid. When the supply rises past its upper threshold, it takes in a two-bit start-up code from an external comparator and enables the charge pump. It then waits a fixed time and turns the buck converters on in a staggered order chosen by that code. It holds an active-low reset output asserted, and keeps the fault protections masked, for a fixed window after the last rail comes up. All times are counted in clock cycles and set by parameters.

The reset output is asserted and all converters are cut when the supply drops below its lower threshold, or when a debounced external reset is held. A control bit can add a delay before the reset output falls. The block also gates the charge pump for thermal shutdown and for sleep, and it signals that configuration registers must return to their defaults.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst_n` is low, `rst_out_n_o`, `cp_en_o`, `conv_b_en_o`, `conv_c_en_o` and `ldo_en_o` are 0, and `prot_mask_o` and `reg_default_o` are 1.
- R2: In the idle state, the first edge that samples `vm_rise_ok`=1 with `vm_fall_hit`=0 and no filtered external reset captures `sel_code`. When the code is not 2'b00, `cp_en_o` rises at that edge and both converters stay off.
- R3: For codes 2'b01, 2'b10 and 2'b11, converter B (`conv_b_en_o`) turns on exactly T_PUMP cycles after `cp_en_o` rises.
- R4: Codes 2'b10 and 2'b11 turn converter C on exactly T_STAGGER cycles after B. Code 2'b01 never turns C on. With the default LDO option, `ldo_en_o` equals `conv_b_en_o`.
- R5: `rst_out_n_o` goes high and `prot_mask_o` goes low exactly T_RELEASE cycles after the last converter of the code turns on.
- R6: Code 2'b00 turns no converter on, and keeps the charge pump off during the wait. `rst_out_n_o` goes high at the (T_QUIET+1)-th edge counted from the edge that samples the rising flag.
- R7: With `rst_dly_en`=0, `vm_fall_hit`=1 or a filtered external reset makes `rst_out_n_o` fall and both converters turn off at the next edge.
- R8: With `rst_dly_en`=1 and the reset released, the same trigger keeps the converters and `rst_out_n_o` unchanged for T_LINGER more cycles. Both then drop at the (T_LINGER+1)-th edge.
- R9: `ext_rst_n` passes SYNC_STAGES flops and then must stay at a new level for FILT_CYC consecutive edges before it takes effect. Shorter pulses are ignored. `reg_default_o` is high while the filtered reset is low.
- R10: `ovp_flag_o` equals `ovp_raw` only while the reset is released; otherwise it is 0. `uvp_flag_o` is also forced to 0 whenever `vm_rise_ok` is 0.
- R11: `cp_en_o` is 0 whenever `tsd_fault`=1. After release, it is 0 when `sleep_n`=0 and no converter is on.
- R12: If `vm_rise_ok` rises again during start-up, the converters turn off at the next edge, and the sequence restarts at the charge-pump step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| vm_rise_ok | input | 1 | Supply above upper threshold |
| vm_fall_hit | input | 1 | Supply below lower threshold |
| sel_code | input | 2 | Start-up code: 00 none, 01 B only, 1x B then C |
| ext_rst_n | input | 1 | Raw external reset, active low |
| rst_dly_en | input | 1 | Delay reset-output assertion |
| sleep_n | input | 1 | Sleep request, active low |
| tsd_fault | input | 1 | Thermal shutdown |
| uvp_raw | input | 1 | Raw undervoltage fault |
| ovp_raw | input | 1 | Raw overvoltage fault |
| cp_en_o | output | 1 | Charge pump enable |
| conv_b_en_o | output | 1 | Converter B enable |
| conv_c_en_o | output | 1 | Converter C enable |
| ldo_en_o | output | 1 | LDO enable |
| rst_out_n_o | output | 1 | Reset output, active low (open-drain level) |
| prot_mask_o | output | 1 | Protection mask window active |
| uvp_flag_o | output | 1 | Masked undervoltage fault |
| ovp_flag_o | output | 1 | Masked overvoltage fault |
| reg_default_o | output | 1 | Registers must take default values |

## Verification
The bench builds the block with short windows: T_PUMP=20, T_STAGGER=15, T_RELEASE=60, T_QUIET=150, T_LINGER=12, FILT_CYC=6 and two synchroniser stages. With these values every start-up code, the delayed and immediate shutdown paths, and a restart in the middle of the release window all fit into a few thousand cycles. Exact edge counts can then be compared with values derived from the parameters. A filter length of six also lets a pulse that is one cycle short of the limit be set against one that just meets it.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUMP,
      ST_STAGGER,
      ST_HOLD,
      ST_QUIET,
      ST_RUN,
      ST_LINGER
   } seq_state_t;

   // start-up code: 00 nothing, 01 converter B only, 1x B then C
   function automatic logic code_has_b(input logic [1:0] code);
      return code != 2'b00;
   endfunction

   function automatic logic code_has_c(input logic [1:0] code);
      return code[1];
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pwr_seq_deglitch.sv
module pwr_seq_deglitch #(
   parameter int   SYNC_STAGES = 2,
   parameter int   FILT_CYC    = 4,
   parameter logic RESET_VAL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CW = $clog2(FILT_CYC + 1);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("pwr_seq_deglitch: SYNC_STAGES must be at least 1");
   end
   if (FILT_CYC < 1) begin : g_bad_filt
      $error("pwr_seq_deglitch: FILT_CYC must be at least 1");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic                   synced;
   logic [CW-1:0]          run_cnt;

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= RESET_VAL;
         else        chain <= din;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {SYNC_STAGES{RESET_VAL}};
         else        chain <= {chain[SYNC_STAGES-2:0], din};
      end
   end

   assign synced = chain[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout    <= RESET_VAL;
         run_cnt <= '0;
      end else if (synced == dout) begin
         run_cnt <= '0;
      end else if (run_cnt == CW'(FILT_CYC - 1)) begin
         dout    <= synced;
         run_cnt <= '0;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_seq_pkg::*;
#(
   parameter int W         = 8,
   parameter int T_PUMP    = 10,
   parameter int T_STAGGER = 10,
   parameter int T_RELEASE = 120,
   parameter int T_QUIET   = 300,
   parameter int T_LINGER  = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rise_ok,
   input  logic         fall_hit,
   input  logic         ext_hold,
   input  logic [1:0]   sel_code,
   input  logic         dly_en,
   input  logic         tmr_done,
   output seq_state_t   state_o,
   output logic [1:0]   code_o,
   output logic         tmr_load,
   output logic [W-1:0] tmr_val
);
   seq_state_t state_q, state_d;
   logic [1:0] code_q, code_d;
   logic       rise_q;
   logic       trig, rose;

   assign trig = fall_hit | ext_hold;
   assign rose = rise_ok & ~rise_q;

   always_comb begin
      state_d  = state_q;
      code_d   = code_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (rise_ok && !trig) begin
               code_d   = sel_code;
               tmr_load = 1'b1;
               if (code_has_b(sel_code)) begin
                  state_d = ST_PUMP;
                  tmr_val = W'(T_PUMP - 1);
               end else begin
                  state_d = ST_QUIET;
                  tmr_val = W'(T_QUIET - 1);
               end
            end
         end
         ST_PUMP, ST_STAGGER, ST_HOLD, ST_QUIET: begin
            if (trig) begin
               state_d = ST_IDLE;
            end else if (rose) begin
               code_d   = sel_code;
               tmr_load = 1'b1;
               if (code_has_b(sel_code)) begin
                  state_d = ST_PUMP;
                  tmr_val = W'(T_PUMP - 1);
               end else begin
                  state_d = ST_QUIET;
                  tmr_val = W'(T_QUIET - 1);
               end
            end else if (tmr_done) begin
               tmr_load = 1'b1;
               if (state_q == ST_PUMP && code_has_c(code_q)) begin
                  state_d = ST_STAGGER;
                  tmr_val = W'(T_STAGGER - 1);
               end else if (state_q == ST_PUMP || state_q == ST_STAGGER) begin
                  state_d = ST_HOLD;
                  tmr_val = W'(T_RELEASE - 1);
               end else begin
                  state_d  = ST_RUN;
                  tmr_load = 1'b0;
               end
            end
         end
         ST_RUN: begin
            if (trig) begin
               if (dly_en) begin
                  state_d  = ST_LINGER;
                  tmr_load = 1'b1;
                  tmr_val  = W'(T_LINGER - 1);
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         ST_LINGER: begin
            if (tmr_done || (trig && !dly_en)) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         code_q  <= 2'b00;
         rise_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         code_q  <= code_d;
         rise_q  <= rise_ok;
      end
   end

   assign state_o = state_q;
   assign code_o  = code_q;
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
   import pwr_seq_pkg::*;
#(
   parameter int T_PUMP       = 10000,
   parameter int T_STAGGER    = 10000,
   parameter int T_RELEASE    = 120000,
   parameter int T_QUIET      = 300000,
   parameter int T_LINGER     = 100,
   parameter int SYNC_STAGES  = 2,
   parameter int FILT_CYC     = 5,
   parameter bit LDO_TRACKS_B = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vm_rise_ok,
   input  logic       vm_fall_hit,
   input  logic [1:0] sel_code,
   input  logic       ext_rst_n,
   input  logic       rst_dly_en,
   input  logic       sleep_n,
   input  logic       tsd_fault,
   input  logic       uvp_raw,
   input  logic       ovp_raw,
   output logic       cp_en_o,
   output logic       conv_b_en_o,
   output logic       conv_c_en_o,
   output logic       ldo_en_o,
   output logic       rst_out_n_o,
   output logic       prot_mask_o,
   output logic       uvp_flag_o,
   output logic       ovp_flag_o,
   output logic       reg_default_o
);
   localparam int MAX_T = max_of(max_of(max_of(T_PUMP, T_STAGGER),
                                        max_of(T_RELEASE, T_QUIET)), T_LINGER);
   localparam int W     = $clog2(MAX_T + 1);

   if (T_PUMP < 2 || T_STAGGER < 2 || T_RELEASE < 2 || T_QUIET < 2 || T_LINGER < 2)
   begin : g_bad_time
      $error("pwr_seq_top: every phase length must be at least 2 cycles");
   end

   logic         ext_filt_n;
   logic         tmr_load, tmr_done;
   logic [W-1:0] tmr_val;
   seq_state_t   state;
   logic [1:0]   code;
   logic         released, ramping, on_b, on_c;

   pwr_seq_deglitch #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILT_CYC),
      .RESET_VAL  (1'b1)
   ) u_deglitch (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ext_rst_n),
      .dout (ext_filt_n)
   );

   pwr_seq_timer #(.W(W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .load_val(tmr_val),
      .done    (tmr_done)
   );

   pwr_seq_fsm #(
      .W        (W),
      .T_PUMP   (T_PUMP),
      .T_STAGGER(T_STAGGER),
      .T_RELEASE(T_RELEASE),
      .T_QUIET  (T_QUIET),
      .T_LINGER (T_LINGER)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_ok (vm_rise_ok),
      .fall_hit(vm_fall_hit),
      .ext_hold(~ext_filt_n),
      .sel_code(sel_code),
      .dly_en  (rst_dly_en),
      .tmr_done(tmr_done),
      .state_o (state),
      .code_o  (code),
      .tmr_load(tmr_load),
      .tmr_val (tmr_val)
   );

   assign released = (state == ST_RUN) || (state == ST_LINGER);
   assign ramping  = (state == ST_PUMP) || (state == ST_STAGGER) || (state == ST_HOLD);
   assign on_b     = code_has_b(code) &&
                     (state == ST_STAGGER || state == ST_HOLD || released);
   assign on_c     = code_has_c(code) && (state == ST_HOLD || released);

   assign conv_b_en_o   = on_b;
   assign conv_c_en_o   = on_c;
   assign cp_en_o       = ~tsd_fault & (ramping | (released & (on_b | on_c | sleep_n)));
   assign rst_out_n_o   = released;
   assign prot_mask_o   = ~released;
   assign ovp_flag_o    = ovp_raw & released;
   assign uvp_flag_o    = uvp_raw & released & vm_rise_ok;
   assign reg_default_o = ~rst_n | ~ext_filt_n;

   if (LDO_TRACKS_B) begin : g_ldo_b
      assign ldo_en_o = on_b;
   end else begin : g_ldo_c
      assign ldo_en_o = on_c;
   end
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic vm_fall_hit,
   input logic rst_dly_en,
   input logic tsd_fault,
   input logic cp_en_o,
   input logic conv_b_en_o,
   input logic conv_c_en_o,
   input logic rst_out_n_o,
   input logic ovp_flag_o,
   input logic reg_default_o
);
   p_idle_on_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_out_n_o) |-> (!conv_b_en_o && !conv_c_en_o));

   p_c_needs_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_c_en_o |-> conv_b_en_o);

   p_fall_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (vm_fall_hit && !rst_dly_en) |=> !rst_out_n_o);

   p_ext_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_default_o && !rst_dly_en) |=> !rst_out_n_o);

   p_ovp_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_out_n_o |-> !ovp_flag_o);

   p_tsd_pump_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tsd_fault |-> !cp_en_o);

   p_conv_pumped_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_b_en_o && !tsd_fault) |-> cp_en_o);
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .vm_fall_hit  (vm_fall_hit),
   .rst_dly_en   (rst_dly_en),
   .tsd_fault    (tsd_fault),
   .cp_en_o      (cp_en_o),
   .conv_b_en_o  (conv_b_en_o),
   .conv_c_en_o  (conv_c_en_o),
   .rst_out_n_o  (rst_out_n_o),
   .ovp_flag_o   (ovp_flag_o),
   .reg_default_o(reg_default_o)
);

// File: tb/pwr_seq_top_tb.sv
module pwr_seq_top_tb;
   localparam int TP = 20, TS = 15, TR = 60, TQ = 150, TL = 12, FC = 6, SS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vm_rise_ok = 1'b0, vm_fall_hit = 1'b1, ext_rst_n = 1'b1;
   logic [1:0] sel_code = 2'b10;
   logic rst_dly_en = 1'b0, sleep_n = 1'b1, tsd_fault = 1'b0, uvp_raw = 1'b0, ovp_raw = 1'b0;
   logic cp_en_o, conv_b_en_o, conv_c_en_o, ldo_en_o, rst_out_n_o;
   logic prot_mask_o, uvp_flag_o, ovp_flag_o, reg_default_o;

   int checks = 0, errors = 0, cycles = 0;

   always #5 clk = ~clk;

   pwr_seq_top #(
      .T_PUMP(TP), .T_STAGGER(TS), .T_RELEASE(TR), .T_QUIET(TQ), .T_LINGER(TL),
      .SYNC_STAGES(SS), .FILT_CYC(FC), .LDO_TRACKS_B(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .vm_rise_ok(vm_rise_ok), .vm_fall_hit(vm_fall_hit),
      .sel_code(sel_code), .ext_rst_n(ext_rst_n), .rst_dly_en(rst_dly_en),
      .sleep_n(sleep_n), .tsd_fault(tsd_fault), .uvp_raw(uvp_raw), .ovp_raw(ovp_raw),
      .cp_en_o(cp_en_o), .conv_b_en_o(conv_b_en_o), .conv_c_en_o(conv_c_en_o),
      .ldo_en_o(ldo_en_o), .rst_out_n_o(rst_out_n_o), .prot_mask_o(prot_mask_o),
      .uvp_flag_o(uvp_flag_o), .ovp_flag_o(ovp_flag_o), .reg_default_o(reg_default_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic probe(input int w);
      case (w)
         0: return cp_en_o;
         1: return conv_b_en_o;
         2: return conv_c_en_o;
         3: return rst_out_n_o;
         default: return reg_default_o;
      endcase
   endfunction

   // number of rising edges until the probed output changes
   task automatic measure(input int w, output int n);
      logic v0 = probe(w);
      n = 0;
      while (probe(w) == v0 && n < 4000) begin
         @(posedge clk);
         @(negedge clk);
         n++;
      end
   endtask

   function automatic logic exp_b(input logic [1:0] c); return c != 2'b00; endfunction
   function automatic logic exp_c(input logic [1:0] c); return c[1];       endfunction

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) begin @(posedge clk); @(negedge clk); end
   endtask

   // checks from the charge-pump rise onward, for a code with converter B
   task automatic ramp_rest(input logic [1:0] c);
      int n;
      measure(1, n); chk("R3 pump to B", n, TP);
      chk("R4 ldo follows B", ldo_en_o, conv_b_en_o);
      if (exp_c(c)) begin
         measure(2, n); chk("R4 B to C", n, TS);
      end
      measure(3, n); chk("R5 release delay", n, TR);
      chk("R4 C per code", conv_c_en_o, exp_c(c));
      chk("R5 mask cleared", prot_mask_o, 0);
   endtask

   task automatic power_up(input logic [1:0] c);
      int n;
      sel_code = c; vm_fall_hit = 1'b0; vm_rise_ok = 1'b1;
      if (exp_b(c)) begin
         measure(0, n); chk("R2 pump first", n, 1);
         chk("R2 converters off with pump", conv_b_en_o | conv_c_en_o, 0);
         ramp_rest(c);
      end else begin
         measure(0, n); chk("R6 quiet wait", n, TQ + 1);
         chk("R6 released with pump", rst_out_n_o, 1);
         chk("R6 no converter", conv_b_en_o | conv_c_en_o, 0);
      end
   endtask

   task automatic power_down(input logic d);
      int n;
      rst_dly_en = d; vm_fall_hit = 1'b1; vm_rise_ok = 1'b0;
      measure(3, n);
      if (d) chk("R8 delayed drop", n, TL + 1);
      else   chk("R7 immediate drop", n, 1);
      chk("R7 converters cut", conv_b_en_o | conv_c_en_o, 0);
      rst_dly_en = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n;
      logic ok;
      void'($urandom(32'd4242));
      @(negedge clk);
      chk("R1 reset out low", rst_out_n_o, 0);
      chk("R1 outputs off", cp_en_o | conv_b_en_o | conv_c_en_o | ldo_en_o, 0);
      chk("R1 mask and defaults", prot_mask_o & reg_default_o, 1);
      idle(2);
      rst_n = 1'b1;
      idle(2);
      chk("R1 idle after reset", rst_out_n_o | cp_en_o, 0);

      // directed: each code, both shutdown styles
      power_up(2'b10); power_down(1'b0);
      power_up(2'b01); power_down(1'b1);
      power_up(2'b00);
      // R11 sleep and thermal gating with no converter
      sleep_n = 1'b0; #1 chk("R11 sleep stops idle pump", cp_en_o, 0);
      sleep_n = 1'b1; #1 chk("R11 pump back on wake", cp_en_o, 1);
      idle(1);
      power_down(1'b0);

      // random cycles
      for (int k = 0; k < 6; k++) begin
         logic [1:0] c = 2'($urandom % 4);
         logic d = 1'($urandom % 2);
         power_up(c);
         power_down(d);
      end

      // R12 restart inside the release window, R10 mask during start-up
      power_up_partial: begin
         sel_code = 2'b11; vm_fall_hit = 1'b0; vm_rise_ok = 1'b1;
         measure(0, n); chk("R2 pump first", n, 1);
         measure(1, n); chk("R3 pump to B", n, TP);
         measure(2, n); chk("R4 B to C", n, TS);
         ovp_raw = 1'b1; #1 chk("R10 ovp masked in window", ovp_flag_o, 0);
         ovp_raw = 1'b0;
         idle(3);
         vm_rise_ok = 1'b0; idle(4);
         vm_rise_ok = 1'b1;
         measure(1, n); chk("R12 converters cut on restart", n, 1);
         chk("R12 C cut and pump kept", {conv_c_en_o, cp_en_o}, 2'b01);
         ramp_rest(2'b11);
      end

      // R10 masking once released
      uvp_raw = 1'b1; ovp_raw = 1'b1;
      #1 chk("R10 flags pass when released", {uvp_flag_o, ovp_flag_o}, 2'b11);
      vm_rise_ok = 1'b0;
      #1 chk("R10 uvp hidden below upper threshold", {uvp_flag_o, ovp_flag_o}, 2'b01);
      idle(3);
      chk("R10 no reset from dip", rst_out_n_o, 1);
      vm_rise_ok = 1'b1; uvp_raw = 1'b0; ovp_raw = 1'b0;
      idle(1);

      // R11 with converters running
      sleep_n = 1'b0; #1 chk("R11 pump stays with converters", cp_en_o, 1);
      tsd_fault = 1'b1; #1 chk("R11 thermal stops pump", cp_en_o, 0);
      tsd_fault = 1'b0; sleep_n = 1'b1;
      idle(1);

      // R9 short external pulse filtered
      ext_rst_n = 1'b0; idle(FC - 1); ext_rst_n = 1'b1;
      ok = 1'b1;
      for (int i = 0; i < 20; i++) begin
         idle(1);
         if (!rst_out_n_o || reg_default_o) ok = 1'b0;
      end
      chk("R9 short pulse ignored", ok, 1);

      // R9 long external reset
      ext_rst_n = 1'b0;
      measure(4, n); chk("R9 filter latency", n, SS + FC);
      measure(3, n); chk("R9 reset follows filter", n, 1);
      idle(5);
      ext_rst_n = 1'b1;
      measure(0, n); chk("R9 restart after release", n, SS + FC + 1);
      ramp_rest(2'b11);
      power_down(1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule